// File: doc/BRIEF.md
# GPIO Bank with Wake Events

This block is an eight-pin general-purpose I/O bank behind a plain synchronous address/data register port. Every pin has its own direction bit, inversion bit and output latch. A pin that is set as an output drives its latched value through the inversion stage. A pin that is set as an input is sampled through a two-flop synchronizer, and software reads it back through the same inversion.

Three of the pins can also wake the system. Each of these pins has an edge polarity select and a sticky status flag. It also has two route masks: one feeds an active-low power-event output and the other feeds an active-low management-event output. Edges are detected on the raw synchronized pin level, before inversion. Software clears a status flag by writing 1 to its bit.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` all 0), inversion is 0, polarity, both route masks and all status flags are 0, and both wake outputs are high.
- R2: A bit written 0 at address 0 (direction) sets that pin's `pin_oe` to 1, and a bit written 1 sets it to 0. `pin_oe` changes only on a write to address 0.
- R3: `pin_out` equals the data latch (written at address 2) XOR the inversion register (address 1), bit by bit.
- R4: A read of address 2 returns, for input pins, the synchronized pin XOR inversion, and for output pins, the latched data as it was written.
- R5: Edges on pins 0 to 4 never set any status flag.
- R6: Polarity at address 3 uses bit k for pin 5+k. A bit of 0 detects rising edges and a bit of 1 detects falling edges, judged on the raw pin level whatever the inversion.
- R7: Status at address 6 uses bit k for pin 5+k. A flag stays set until a write to address 6 with 1 in that bit. Writing 0 has no effect, and an edge detected in the same cycle as the clear leaves the flag set.
- R8: `pwr_wake_n` is low exactly while some status flag is set whose bit is set in the power route mask (address 4, bit k for pin 5+k).
- R9: `mgmt_wake_n` is low exactly while some status flag is set whose bit is set in the management route mask (address 5, bit k for pin 5+k).
- R10: A pin change applied before clock edge 1 shows in the status flag after edge 3: two edges of synchronizer and one edge of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin output enables, 1 = drive |
| pwr_wake_n | output | 1 | Active-low power wake event |
| mgmt_wake_n | output | 1 | Active-low management wake event |

## Verification
The bench builds the block with its default parameters: eight pins, with the wake-capable group at pins 5 to 7. With these values the bench can run mixed direction and inversion patterns in which wake pins and plain pins toggle together. It can also show that edges on the low five pins leave status untouched. The same build covers the exact three-edge latency, a falling edge on an inverted pin, and a clear that arrives in the same cycle as a new edge.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_DIR   = 3'd0,
    A_INV   = 3'd1,
    A_DATA  = 3'd2,
    A_POL   = 3'd3,
    A_RPWR  = 3'd4,
    A_RMGMT = 3'd5,
    A_STAT  = 3'd6
  } gpio_addr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end
  assign srst_n = stg_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end
  assign q = s2_q;
endmodule

// File: rtl/gpio_wake_cell.sv
module gpio_wake_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic lvl,
  input  logic pol,
  input  logic clr,
  output logic status
);
  logic prev_q, stat_q, stat_d, hit;

  always_comb begin
    hit    = armed & (pol ? (~lvl & prev_q) : (lvl & ~prev_q));
    stat_d = hit | (stat_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned WAKE_LO = 5,
  parameter int unsigned NWAKE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic [NPIN-1:0]   reg_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              pwr_wake_n,
  output logic              mgmt_wake_n
);
  localparam int unsigned ARM_W = 3;

  logic              irst_n;
  logic [NPIN-1:0]   sync_q;
  logic [NPIN-1:0]   dir_q, dir_d, inv_q, inv_d, dout_q, dout_d;
  logic [NWAKE-1:0]  pol_q, pol_d, rpwr_q, rpwr_d, rmgmt_q, rmgmt_d;
  logic [NWAKE-1:0]  status_q, clr_bits;
  logic [ARM_W-1:0]  arm_q;
  logic              wr_dir, wr_inv, wr_data, wr_pol, wr_rpwr, wr_rmgmt, wr_stat;

  gpio_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(irst_n));

  gpio_sync #(.W(NPIN)) u_sync (.clk(clk), .rst_n(irst_n), .d(pin_in), .q(sync_q));

  // write decode
  always_comb begin
    wr_dir   = reg_we && (reg_addr == A_DIR);
    wr_inv   = reg_we && (reg_addr == A_INV);
    wr_data  = reg_we && (reg_addr == A_DATA);
    wr_pol   = reg_we && (reg_addr == A_POL);
    wr_rpwr  = reg_we && (reg_addr == A_RPWR);
    wr_rmgmt = reg_we && (reg_addr == A_RMGMT);
    wr_stat  = reg_we && (reg_addr == A_STAT);
    clr_bits = wr_stat ? reg_wdata[NWAKE-1:0] : '0;
  end

  // next state
  always_comb begin
    dir_d   = wr_dir   ? reg_wdata              : dir_q;
    inv_d   = wr_inv   ? reg_wdata              : inv_q;
    dout_d  = wr_data  ? reg_wdata              : dout_q;
    pol_d   = wr_pol   ? reg_wdata[NWAKE-1:0]   : pol_q;
    rpwr_d  = wr_rpwr  ? reg_wdata[NWAKE-1:0]   : rpwr_q;
    rmgmt_d = wr_rmgmt ? reg_wdata[NWAKE-1:0]   : rmgmt_q;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      dir_q   <= '1;
      inv_q   <= '0;
      dout_q  <= '0;
      pol_q   <= '0;
      rpwr_q  <= '0;
      rmgmt_q <= '0;
      arm_q   <= '0;
    end else begin
      dir_q   <= dir_d;
      inv_q   <= inv_d;
      dout_q  <= dout_d;
      pol_q   <= pol_d;
      rpwr_q  <= rpwr_d;
      rmgmt_q <= rmgmt_d;
      arm_q   <= {arm_q[ARM_W-2:0], 1'b1};
    end
  end

  genvar k;
  generate
    for (k = 0; k < NWAKE; k++) begin : g_wake
      gpio_wake_cell u_cell (
        .clk   (clk),
        .rst_n (irst_n),
        .armed (arm_q[ARM_W-1]),
        .lvl   (sync_q[WAKE_LO+k]),
        .pol   (pol_q[k]),
        .clr   (clr_bits[k]),
        .status(status_q[k])
      );
    end
  endgenerate

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_INV:   reg_rdata = inv_q;
      A_DATA:  reg_rdata = (dir_q & (sync_q ^ inv_q)) | (~dir_q & dout_q);
      A_POL:   reg_rdata[NWAKE-1:0] = pol_q;
      A_RPWR:  reg_rdata[NWAKE-1:0] = rpwr_q;
      A_RMGMT: reg_rdata[NWAKE-1:0] = rmgmt_q;
      A_STAT:  reg_rdata[NWAKE-1:0] = status_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out     = dout_q ^ inv_q;
  assign pin_oe      = ~dir_q;
  assign pwr_wake_n  = ~|(status_q & rpwr_q);
  assign mgmt_wake_n = ~|(status_q & rmgmt_q);
endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NPIN    = 8,
  parameter int unsigned WAKE_LO = 5,
  parameter int unsigned NWAKE   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NWAKE-1:0]  status,
  input logic [NWAKE-1:0]  route_pwr,
  input logic [NWAKE-1:0]  route_mgmt,
  input logic              pwr_wake_n,
  input logic              mgmt_wake_n
);
  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_DIR) |=> $stable(pin_oe));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_STAT) |=> ((status & $past(status)) == $past(status)));

  assert_pwr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_pwr == '0) |-> pwr_wake_n);

  assert_mgmt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mgmt == '0) |-> mgmt_wake_n);

  genvar k;
  generate
    for (k = 0; k < NWAKE; k++) begin : g_src
      assert_edge_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[k]) |-> ($past(pin_in[WAKE_LO+k], 3) != $past(pin_in[WAKE_LO+k], 4)));
    end
  endgenerate
endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(.NPIN(NPIN), .WAKE_LO(WAKE_LO), .NWAKE(NWAKE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .pin_in     (pin_in),
  .pin_oe     (pin_oe),
  .status     (status_q),
  .route_pwr  (rpwr_q),
  .route_mgmt (rmgmt_q),
  .pwr_wake_n (pwr_wake_n),
  .mgmt_wake_n(mgmt_wake_n)
);

// File: tb/sim_gpio_wake_bank.sv
module sim_gpio_wake_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {dir, inv, data, pin, exp pin_out, exp pin_oe, exp read of data}
  localparam logic [55:0] VEC [NVEC] = '{
    56'hFF_00_00_A5_00_00_A5,
    56'h00_00_3C_FF_3C_FF_3C,
    56'h00_FF_3C_00_C3_FF_3C,
    56'hF0_0F_55_A0_5A_0F_A5,
    56'h0F_33_81_96_B2_F0_85
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = 8'd0;
  logic [7:0] pin_out, pin_oe;
  logic       pwr_wake_n, mgmt_wake_n;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_wake_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pwr_wake_n(pwr_wake_n),
    .mgmt_wake_n(mgmt_wake_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    step(2);
    rst_n = 1'b1;
    step(6);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 wake", {6'd0, pwr_wake_n, mgmt_wake_n}, 8'h03);
    rd(3'd0, v); chk("R1 dir", v, 8'hFF);
    rd(3'd1, v); chk("R1 inv", v, 8'h00);
    rd(3'd3, v); chk("R1 pol", v, 8'h00);
    rd(3'd6, v); chk("R1 status", v, 8'h00);

    // table walk: R2 R3 R4
    for (int i = 0; i < NVEC; i++) begin
      pin_in = VEC[i][31:24];
      wr(3'd0, VEC[i][55:48]);
      wr(3'd1, VEC[i][47:40]);
      wr(3'd2, VEC[i][39:32]);
      step(2);
      chk("R3 pin_out", pin_out, VEC[i][23:16]);
      chk("R2 pin_oe", pin_oe, VEC[i][15:8]);
      rd(3'd2, v); chk("R4 data read", v, VEC[i][7:0]);
    end

    // back to inputs, clear anything the table set
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h00);
    pin_in = 8'h00;
    step(4);
    wr(3'd6, 8'h07);
    rd(3'd6, v); chk("R7 clear all", v, 8'h00);

    // R5 low pins never raise events
    pin_in = 8'h1F; step(4);
    pin_in = 8'h00; step(4);
    rd(3'd6, v); chk("R5 low pins", v, 8'h00);

    // R10 latency on pin 5, rising
    pin_in = 8'h20;
    step(2);
    rd(3'd6, v); chk("R10 not yet after 2 edges", v, 8'h00);
    step(1);
    rd(3'd6, v); chk("R10 set after 3 edges", v, 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd6, v); chk("R7 w1c", v, 8'h00);

    // R6 falling on rising-polarity pin: no event
    pin_in = 8'h00; step(4);
    rd(3'd6, v); chk("R6 fall ignored rising pol", v, 8'h00);

    // R6 pin 6 set for falling
    wr(3'd3, 8'h02);
    pin_in = 8'h40; step(4);
    rd(3'd6, v); chk("R6 rise ignored falling pol", v, 8'h00);
    pin_in = 8'h00; step(4);
    rd(3'd6, v); chk("R6 falling detected", v, 8'h02);

    // R6 raw level: pin 7 inverted, rising raw edge detected
    wr(3'd1, 8'h80);
    pin_in = 8'h80; step(4);
    rd(3'd6, v); chk("R6 raw before inversion", v, 8'h06);

    // R8 R9 routing
    wr(3'd4, 8'h01);
    chk("R8 unrouted high", {7'd0, pwr_wake_n}, 8'h01);
    wr(3'd4, 8'h04);
    chk("R8 routed low", {7'd0, pwr_wake_n}, 8'h00);
    wr(3'd5, 8'h02);
    chk("R9 routed low", {7'd0, mgmt_wake_n}, 8'h00);
    wr(3'd6, 8'h02);
    chk("R9 cleared high", {7'd0, mgmt_wake_n}, 8'h01);
    chk("R8 still low", {7'd0, pwr_wake_n}, 8'h00);
    wr(3'd6, 8'h00);
    rd(3'd6, v); chk("R7 zero write no effect", v, 8'h04);

    // R7 set wins over clear on the same cycle
    pin_in = 8'hA0; step(4);
    rd(3'd6, v); chk("R7 pin5 set", v, 8'h05);
    pin_in = 8'h80; step(4);
    pin_in = 8'hA0;
    step(2);
    wr(3'd6, 8'h01);
    rd(3'd6, v); chk("R7 set beats clear", v, 8'h05);
    wr(3'd6, 8'h05);
    rd(3'd6, v); chk("R7 cleared", v, 8'h00);
    chk("R8 idle after clear", {7'd0, pwr_wake_n}, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule